// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit carries out the shift and rotate group of a 16-bit processor datapath, one bit position per clock. A caller presents an 8-bit or 16-bit operand, a 3-bit operation code, a count taken from either an immediate byte or the low byte of the count register, and the incoming carry and overflow flags. It then pulses `start`. The unit drops `busy` and raises `done` for one cycle once the result and flags are final.

Each operation first spends a fixed setup delay. The delay is 9 cycles when the operand came from memory and 6 cycles when it came from a register. The count is normally cut down to its low five bits. A compatibility input lets the full byte count through, so up to 255 single-bit steps may run. An effective count of zero returns the operand and both incoming flags untouched. Decode, operand fetch and writeback belong to the surrounding pipeline.

Top module: `shrot_unit`

## Requirements
- R1: With `wide`=1 the operation acts on all 16 bits. With `wide`=0 it acts on `operand[7:0]` only, and `result[15:8]` reads zero once the operation completes.
- R2: With `cnt_sel`=0 the raw count is `imm_cnt`. With `cnt_sel`=1 it is `creg_low`, which is the low byte of the count register, and the other count input has no effect.
- R3: With `compat`=0 the effective count is the raw count ANDed with 0x1F, so a raw count of 0x21 performs one step.
- R4: With `compat`=1 the full 8-bit raw count is used, up to 255 steps.
- R5: `done` is high in the cycle that follows edge S+C+1, counted after the edge that accepted `start`. S is 9 when `mem_src`=1 and 6 when `mem_src`=0, and C is the effective count.
- R6: The `op` encoding is: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 shift left, 5 shift right logical, 6 shift left (same as 4), 7 shift right arithmetic. After each step, `carry_out` holds the bit that was shifted out last.
- R7: The through-carry rotates (codes 2 and 3) treat the carry as one more bit. This makes a 9-bit rotation for byte operands and a 17-bit rotation for word operands.
- R8: Shift left and shift right logical fill the vacated bit with 0. Shift right arithmetic copies the sign bit into it.
- R9: After a nonzero count, `ovf_out` depends on the direction. For left operations (even codes) it is the result MSB XOR `carry_out`. For right operations (odd codes) it is the result MSB XOR the bit below it.
- R10: An effective count of zero gives `result` = operand (byte-masked per R1), `carry_out` = `carry_in` and `ovf_out` = `ovf_in`.
- R11: A `start` pulse while `busy` is high is ignored. It does not change the running operation, its latency, or the number of `done` pulses.
- R12: After reset, `busy`, `done`, `result`, `carry_out` and `ovf_out` are all 0. `busy` is high from the edge that accepts `start` until the edge that raises `done`, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| op | input | 3 | Operation code (see R6) |
| cnt_sel | input | 1 | 0 = immediate count, 1 = count register low byte |
| imm_cnt | input | 8 | Immediate count byte |
| creg_low | input | 8 | Low byte of the count register |
| compat | input | 1 | 1 = use count unmasked |
| mem_src | input | 1 | 1 = operand came from memory (longer setup) |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| operand | input | 16 | Value to shift or rotate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted or rotated value |
| carry_out | output | 1 | Resulting carry flag |
| ovf_out | output | 1 | Resulting overflow flag |

## Verification
The bench aims at the masking boundary first. A raw count of 0x21 must perform one step and a raw count of 0x20 none; a unit that did not mask would shift the word away, and one that masked wrongly would keep data it should move. In compatibility mode a 17-step shift and a 200-step byte rotate catch a count register that is too narrow or that wraps early. The through-carry rotates are driven by 9 and by 31 steps: a design that rotated over 8 bits instead of 9 would return a different byte and carry. Latency is measured on every operation, so an off-by-one in the setup delay or in the step count shows up, as do a zero count that loses its incoming flags and a second `start` that restarts a running operation.

// File: rtl/shrot_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes op codes follow the 3-bit selector order: even codes move left, odd codes move right.
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAL = 3'd6,
        OP_SAR = 3'd7
    } shrot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } shrot_st_e;

    // Left-moving operations have an even code.
    function automatic logic op_is_left(input shrot_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/shrot_count.sv
// Count selection and masking.
// Chooses the immediate byte or the count-register byte. Unless compat is set, it keeps only
// the low MASK_W bits. Purely combinational; assumes MASK_W < CNT_W.
module shrot_count #(
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input  logic             cnt_sel,
    input  logic [CNT_W-1:0] imm_cnt,
    input  logic [CNT_W-1:0] creg_low,
    input  logic             compat,
    output logic [CNT_W-1:0] eff_cnt
);
    localparam logic [CNT_W-1:0] CNT_MASK = CNT_W'((1 << MASK_W) - 1);

    logic [CNT_W-1:0] raw_cnt;

    // Pick the count source.
    always_comb raw_cnt = cnt_sel ? creg_low : imm_cnt;

    // Apply the default-mode mask.
    always_comb eff_cnt = compat ? raw_cnt : (raw_cnt & CNT_MASK);

endmodule

// File: rtl/shrot_lane.sv
// One single-bit step of the shift/rotate group on a W-bit value.
// Combinational; assumes W >= 2. Byte and word lanes are both built from this module.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] d,
    input  logic         cin,
    input  shrot_op_e    op,
    output logic [W-1:0] q,
    output logic         cout
);
    // Compute the next value and the bit shifted out.
    always_comb begin
        q    = d;
        cout = cin;
        unique case (op)
            OP_ROL: begin q = {d[W-2:0], d[W-1]}; cout = d[W-1]; end
            OP_ROR: begin q = {d[0], d[W-1:1]};   cout = d[0];   end
            OP_RCL: begin q = {d[W-2:0], cin};    cout = d[W-1]; end
            OP_RCR: begin q = {cin, d[W-1:1]};    cout = d[0];   end
            OP_SHL,
            OP_SAL: begin q = {d[W-2:0], 1'b0};   cout = d[W-1]; end
            OP_SHR: begin q = {1'b0, d[W-1:1]};   cout = d[0];   end
            OP_SAR: begin q = {d[W-1], d[W-1:1]}; cout = d[0];   end
            default: begin q = d; cout = cin; end
        endcase
    end

endmodule

// File: rtl/shrot_seq.sv
// Sequencer: idle, a fixed setup delay, then one step per cycle until the count is used up.
// The setup length comes from the operand source. Assumes MEM_SETUP and REG_SETUP are >= 1.
// done is registered and lasts one cycle; start is only accepted in idle.
module shrot_seq
    import shrot_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int MASK_W    = 5,
    parameter int MEM_SETUP = 9,
    parameter int REG_SETUP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mem_src,
    input  logic             compat,
    input  logic [CNT_W-1:0] eff_cnt,
    output logic             load,
    output logic             step_en,
    output logic             finish,
    output logic             busy,
    output logic             done
);
    localparam int SETUP_MAX = (MEM_SETUP > REG_SETUP) ? MEM_SETUP : REG_SETUP;
    localparam int SETUP_W   = $clog2(SETUP_MAX + 1);

    shrot_st_e          state;
    logic [SETUP_W-1:0] setup_cnt;
    logic [CNT_W-1:0]   rem;

    // Decode the per-cycle actions from the current state.
    always_comb begin
        load    = start && (state == ST_IDLE);
        step_en = (state == ST_RUN) && (rem != '0);
        finish  = (state == ST_RUN) && (rem == '0);
        busy    = (state != ST_IDLE);
    end

    // State, setup delay and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            setup_cnt <= '0;
            rem       <= '0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_SETUP;
                        setup_cnt <= mem_src ? SETUP_W'(MEM_SETUP) : SETUP_W'(REG_SETUP);
                        rem       <= eff_cnt;
                    end
                end
                ST_SETUP: begin
                    if (setup_cnt <= SETUP_W'(1)) begin
                        state <= ST_RUN;
                    end else begin
                        setup_cnt <= setup_cnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (rem == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R12
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish && start) |=> (busy && $stable(rem) || step_en || $past(step_en))); // R11
    AST_SETUP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |=> (rem == $past(rem))); // R5
    AST_MASKED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !compat) |=> (rem < CNT_W'(1 << MASK_W))); // R3

endmodule

// File: rtl/shrot_datapath.sv
// Working register and flags.
// On load it captures the operand (cleared above the low byte for byte operations) and the
// incoming flags. Each step takes the next value from the lane that matches the width. The
// overflow flag is settled in the finish cycle, and only if at least one step ran.
module shrot_datapath
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  logic              finish,
    input  logic              wide,
    input  shrot_op_e         op,
    input  logic              cnt_nz,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic              ovf_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              ovf_out
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int N_LANES = 2;

    logic [DATA_W-1:0] work;
    logic              cy;
    logic              ov;
    logic              wide_q;
    logic              nz_q;
    shrot_op_e         op_q;

    logic [DATA_W-1:0] lane_q    [N_LANES];
    logic              lane_cout [N_LANES];
    logic              top_bit;
    logic              next_bit;

    // Lane 0 is the full word and lane 1 is the low byte.
    for (genvar g = 0; g < N_LANES; g++) begin : gen_lane
        localparam int LW = (g == 0) ? DATA_W : HALF_W;
        logic [LW-1:0] q_w;
        shrot_lane #(.W(LW)) u_lane (
            .d    (work[LW-1:0]),
            .cin  (cy),
            .op   (op_q),
            .q    (q_w),
            .cout (lane_cout[g])
        );
        assign lane_q[g] = DATA_W'(q_w);
    end

    // Pick the MSB and the bit below it for the active width.
    always_comb begin
        top_bit  = wide_q ? work[DATA_W-1] : work[HALF_W-1];
        next_bit = wide_q ? work[DATA_W-2] : work[HALF_W-2];
    end

    // Load, step and settle the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work   <= '0;
            cy     <= 1'b0;
            ov     <= 1'b0;
            wide_q <= 1'b0;
            nz_q   <= 1'b0;
            op_q   <= OP_ROL;
        end else if (load) begin
            work   <= wide ? operand : {{(DATA_W-HALF_W){1'b0}}, operand[HALF_W-1:0]};
            cy     <= carry_in;
            ov     <= ovf_in;
            wide_q <= wide;
            nz_q   <= cnt_nz;
            op_q   <= op;
        end else if (step_en) begin
            work <= wide_q ? lane_q[0] : lane_q[1];
            cy   <= wide_q ? lane_cout[0] : lane_cout[1];
        end else if (finish && nz_q) begin
            ov <= op_is_left(op_q) ? (top_bit ^ cy) : (top_bit ^ next_bit);
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        result    = work;
        carry_out = cy;
        ovf_out   = ov;
    end

    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (work[DATA_W-1:HALF_W] == '0)); // R1
    AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(result)); // R10
    AST_ZERO_COUNT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !nz_q) |=> ($stable(ovf_out) && $stable(carry_out))); // R10

endmodule

// File: rtl/shrot_unit.sv
// Top of the iterative shift/rotate unit.
// Wires count selection, sequencer and datapath together. Assumes the caller holds the operation
// inputs stable only in the start cycle; everything needed later is captured on load.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int MASK_W    = 5,
    parameter int MEM_SETUP = 9,
    parameter int REG_SETUP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [2:0]        op,
    input  logic              cnt_sel,
    input  logic [CNT_W-1:0]  imm_cnt,
    input  logic [CNT_W-1:0]  creg_low,
    input  logic              compat,
    input  logic              mem_src,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              ovf_out
);
    logic [CNT_W-1:0] eff_cnt;
    logic             load;
    logic             step_en;
    logic             finish;
    logic             cnt_nz;

    // A zero effective count skips the flag update.
    always_comb cnt_nz = (eff_cnt != '0);

    shrot_count #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_count (
        .cnt_sel  (cnt_sel),
        .imm_cnt  (imm_cnt),
        .creg_low (creg_low),
        .compat   (compat),
        .eff_cnt  (eff_cnt)
    );

    shrot_seq #(
        .CNT_W(CNT_W), .MASK_W(MASK_W),
        .MEM_SETUP(MEM_SETUP), .REG_SETUP(REG_SETUP)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mem_src (mem_src),
        .compat  (compat),
        .eff_cnt (eff_cnt),
        .load    (load),
        .step_en (step_en),
        .finish  (finish),
        .busy    (busy),
        .done    (done)
    );

    shrot_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .finish    (finish),
        .wide      (wide),
        .op        (shrot_op_e'(op)),
        .cnt_nz    (cnt_nz),
        .operand   (operand),
        .carry_in  (carry_in),
        .ovf_in    (ovf_in),
        .result    (result),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

endmodule

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        cnt_sel = 1'b0;
    logic [7:0]  imm_cnt = 8'd0;
    logic [7:0]  creg_low = 8'd0;
    logic        compat = 1'b0;
    logic        mem_src = 1'b0;
    logic        carry_in = 1'b0;
    logic        ovf_in = 1'b0;
    logic [15:0] operand = 16'd0;
    logic        busy;
    logic        done;
    logic [15:0] result;
    logic        carry_out;
    logic        ovf_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .op(op),
        .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .creg_low(creg_low), .compat(compat),
        .mem_src(mem_src), .carry_in(carry_in), .ovf_in(ovf_in), .operand(operand),
        .busy(busy), .done(done), .result(result), .carry_out(carry_out), .ovf_out(ovf_out)
    );

    typedef struct packed {
        logic [31:0] tag;
        logic        w;
        logic [2:0]  op;
        logic        cmp;
        logic        mem;
        logic [7:0]  cnt;
        logic        cin;
        logic        oin;
        logic [15:0] opnd;
        logic [15:0] exp_res;
        logic        exp_c;
        logic        exp_o;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{"R6",  1'b0, 3'd0, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 16'h0081, 16'h0003, 1'b1, 1'b1},
        '{"R6",  1'b1, 3'd1, 1'b0, 1'b1, 8'd4,   1'b0, 1'b0, 16'h1234, 16'h4123, 1'b0, 1'b1},
        '{"R7",  1'b0, 3'd2, 1'b0, 1'b0, 8'd9,   1'b1, 1'b0, 16'h005A, 16'h005A, 1'b1, 1'b1},
        '{"R7",  1'b1, 3'd3, 1'b0, 1'b0, 8'd1,   1'b1, 1'b0, 16'h0001, 16'h8000, 1'b1, 1'b1},
        '{"R8",  1'b1, 3'd4, 1'b0, 1'b1, 8'd3,   1'b0, 1'b0, 16'h2001, 16'h0008, 1'b1, 1'b1},
        '{"R8",  1'b0, 3'd5, 1'b0, 1'b0, 8'd2,   1'b0, 1'b0, 16'h0083, 16'h0020, 1'b1, 1'b0},
        '{"R8",  1'b0, 3'd7, 1'b0, 1'b0, 8'd3,   1'b0, 1'b0, 16'h0090, 16'h00F2, 1'b0, 1'b0},
        '{"R9",  1'b0, 3'd6, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 16'h0040, 16'h0080, 1'b0, 1'b1},
        '{"R9",  1'b1, 3'd5, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 16'h8000, 16'h4000, 1'b0, 1'b1},
        '{"R3",  1'b1, 3'd4, 1'b0, 1'b0, 8'h21,  1'b0, 1'b0, 16'h8001, 16'h0002, 1'b1, 1'b1},
        '{"R4",  1'b1, 3'd4, 1'b1, 1'b0, 8'd17,  1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        '{"R10", 1'b1, 3'd0, 1'b0, 1'b0, 8'h20,  1'b1, 1'b1, 16'hBEEF, 16'hBEEF, 1'b1, 1'b1},
        '{"R4",  1'b1, 3'd0, 1'b1, 1'b1, 8'h20,  1'b0, 1'b0, 16'hBEEF, 16'hBEEF, 1'b1, 1'b0},
        '{"R5",  1'b0, 3'd1, 1'b0, 1'b1, 8'd8,   1'b0, 1'b0, 16'h003C, 16'h003C, 1'b0, 1'b0},
        '{"R7",  1'b0, 3'd3, 1'b0, 1'b0, 8'h1F,  1'b1, 1'b0, 16'h0000, 16'h0010, 1'b0, 1'b0},
        '{"R1",  1'b0, 3'd0, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 16'hFF01, 16'h0002, 1'b0, 1'b0},
        '{"R4",  1'b0, 3'd0, 1'b1, 1'b0, 8'd200, 1'b0, 1'b0, 16'h00A5, 16'h00A5, 1'b1, 1'b0},
        '{"R3",  1'b1, 3'd4, 1'b0, 1'b1, 8'h20,  1'b0, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        end
        $finish;
    endtask

    // Called at a falling edge; returns the number of rising edges after the accepting edge.
    task automatic run_op(input logic w, input logic [2:0] o, input logic cmp, input logic mem,
                          input logic sel, input logic [7:0] imm, input logic [7:0] creg,
                          input logic cin, input logic oin, input logic [15:0] opnd,
                          output int edges);
        int lat;
        wide = w; op = o; compat = cmp; mem_src = mem; cnt_sel = sel;
        imm_cnt = imm; creg_low = creg; carry_in = cin; ovf_in = oin; operand = opnd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        edges = lat - 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : main
        int edges;
        int eff;
        int setup;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "busy after reset", 32'(busy), 32'd0);
        check("R12", "done after reset", 32'(done), 32'd0);
        check("R12", "result after reset", 32'(result), 32'd0);
        check("R12", "flags after reset", {30'd0, carry_out, ovf_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            run_op(v.w, v.op, v.cmp, v.mem, 1'b0, v.cnt, 8'h55, v.cin, v.oin, v.opnd, edges);
            eff   = v.cmp ? int'(v.cnt) : int'(v.cnt & 8'h1F);
            setup = v.mem ? 9 : 6;
            check(string'(v.tag), "result", 32'(result), 32'(v.exp_res));
            check(string'(v.tag), "carry", 32'(carry_out), 32'(v.exp_c));
            check(string'(v.tag), "overflow", 32'(ovf_out), 32'(v.exp_o));
            check("R5", "latency", 32'(edges), 32'(setup + eff + 1));
            @(negedge clk);
            // R12: done is a single-cycle pulse
            check("R12", "done one cycle", 32'(done), 32'd0);
        end

        // R2: count taken from the count register's low byte, immediate ignored
        run_op(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 8'h01, 8'h03, 1'b0, 1'b0, 16'h0001, edges);
        check("R2", "register count result", 32'(result), 32'h0008);
        check("R2", "register count latency", 32'(edges), 32'd10);
        @(negedge clk);
        // R2: register byte is masked like any count (0x23 -> 3)
        run_op(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 8'h07, 8'h23, 1'b0, 1'b0, 16'h0001, edges);
        check("R2", "masked register count", 32'(result), 32'h0008);
        @(negedge clk);

        // R11: a second start while busy is ignored
        wide = 1'b1; op = 3'd0; compat = 1'b0; mem_src = 1'b0; cnt_sel = 1'b0;
        imm_cnt = 8'd2; carry_in = 1'b0; ovf_in = 1'b0; operand = 16'h0003;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        repeat (2) begin @(negedge clk); edges++; end
        op = 3'd5; imm_cnt = 8'd5; operand = 16'hFFFF; mem_src = 1'b1; start = 1'b1;
        @(negedge clk);
        edges++;
        start = 1'b0;
        while (!done && edges < 2000) begin @(negedge clk); edges++; end
        check("R11", "result unaffected by second start", 32'(result), 32'h000C);
        check("R11", "latency unaffected by second start", 32'(edges - 1), 32'd9);
        begin
            int extra = 0;
            repeat (30) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R11", "no second done pulse", 32'(extra), 32'd0);
            check("R11", "idle after run", 32'(busy), 32'd0);
        end

        // R12: busy high during operation
        wide = 1'b0; op = 3'd1; imm_cnt = 8'd1; mem_src = 1'b0; operand = 16'h0001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12", "busy after start", 32'(busy), 32'd1);
        while (!done) @(negedge clk);
        check("R12", "busy low at done", 32'(busy), 32'd0);

        report();
    end

endmodule